// File: doc/BRIEF.md
# Input Capture Period Meter

This block timestamps edges on an asynchronous input pin against a free-running 16-bit counter. The counter advances on a tick from a power-of-two prescaler. Each time the counter wraps, a 16-bit wrap count is incremented, so every capture carries a 32-bit timestamp with the wrap count in the upper half. Each capture subtracts the previous timestamp from the new one. The result is a 32-bit period that stays correct across many counter wraps.

The pin goes through a synchronizer before its edges are detected. A 2-bit mode selects which edges cause a capture. Software measures a pulse width in two steps. It captures a rising edge, switches the mode to falling, captures again, and reads the difference of the two captured counts. The period output gives the same value. A capture flag and a wrap flag are each cleared by a one-cycle clear pulse. The two flags drive a single interrupt line through separate enables.

Top module: `capture_period_meter`

## Requirements
- R1: After reset, the counter, wrap count, captured count, paired wrap count and period are zero, and both flags, `period_valid` and `irq` are low.
- R2: While `run_en` is high, the counter advances by one every 2^`presc_sel` clock cycles. While `run_en` is low, the counter holds its value.
- R3: When the counter steps from 0xFFFF to 0x0000, `ovf_flag` is set and `ovf_count` increments by one.
- R4: `edge_sel` encodes the capture mode: 2'b00 captures nothing, 2'b01 captures rising edges, 2'b10 captures falling edges, and 2'b11 captures both.
- R5: A pin change set up before clock edge k is captured at edge k+2. After that edge, `cap_value` equals `cnt_value`.
- R6: A capture sets `cap_flag`. A one-cycle pulse on `cap_flag_clr` clears it. If a capture and a clear fall on the same edge, the flag stays set.
- R7: A pulse on `ovf_flag_clr` clears `ovf_flag`. If a wrap and a clear fall on the same edge, the flag stays set.
- R8: `cap_ovf` always equals the `ovf_count` value that holds right after the capture edge. This includes a capture on the edge where the counter wraps to zero.
- R9: On each capture, `period` becomes the new timestamp {`cap_ovf`,`cap_value`} minus the previous one, modulo 2^32. `period_valid` rises on the second capture after reset.
- R10: A rising capture followed by a falling capture, with the mode switched in between, gives a 16-bit `cap_value` difference equal to the high time in counter ticks.
- R11: `irq` is high whenever `cap_flag` is set with `cap_irq_en` high, or `ovf_flag` is set with `ovf_irq_en` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Counter run enable |
| presc_sel | input | 3 | Prescaler exponent; one tick every 2^presc_sel cycles |
| cap_pin | input | 1 | Asynchronous capture input |
| edge_sel | input | 2 | Capture mode (00 off, 01 rise, 10 fall, 11 both) |
| cap_flag_clr | input | 1 | Clear pulse for the capture flag |
| ovf_flag_clr | input | 1 | Clear pulse for the wrap flag |
| cap_irq_en | input | 1 | Capture interrupt enable |
| ovf_irq_en | input | 1 | Wrap interrupt enable |
| cnt_value | output | 16 | Free-running counter |
| ovf_count | output | 16 | Counter wrap count |
| cap_value | output | 16 | Counter value latched at the last capture |
| cap_ovf | output | 16 | Wrap count paired with the last capture |
| period | output | 32 | Difference of the last two timestamps |
| period_valid | output | 1 | At least two captures since reset |
| cap_flag | output | 1 | Capture event flag |
| ovf_flag | output | 1 | Counter wrap flag |
| irq | output | 1 | Combined interrupt request |

## Verification
Some internal faults show up one edge after the event. A bad prescaler or run gate moves `cnt_value` off the expected count within a few cycles. A wrong edge decode or a broken synchronizer depth shows as a missing, extra or shifted capture; `cap_value` then differs from `cnt_value` at the sample point three cycles after the pin changes. A wrong pairing of the wrap count with the capture is only visible on a capture that lands on the wrap edge. There, `cap_ovf` is one below `ovf_count`, and `period` is off by 65536 from the cycle count between the two pin edges. The bench therefore forces that exact coincidence.

// File: rtl/cpm_pkg.sv
package cpm_pkg;
  localparam int CNT_W = 16;
  localparam int OVF_W = 16;
  localparam int TS_W  = CNT_W + OVF_W;

  typedef logic [CNT_W-1:0] cnt_t;
  typedef logic [OVF_W-1:0] ovf_t;
  typedef logic [TS_W-1:0]  ts_t;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_mode_e;

  // Does a transition prev->cur match the selected mode (R4)
  function automatic logic edge_hit(edge_mode_e mode, logic prev_lvl, logic cur_lvl);
    logic went_up;
    logic went_down;
    went_up   = cur_lvl & ~prev_lvl;
    went_down = ~cur_lvl & prev_lvl;
    case (mode)
      EDGE_RISE: return went_up;
      EDGE_FALL: return went_down;
      EDGE_ANY:  return went_up | went_down;
      default:   return 1'b0;
    endcase
  endfunction

  // Wrap count to pair with a captured count (R8): a capture landing on the
  // wrap edge sees the new low count but the old wrap count.
  function automatic ovf_t pair_ovf(ovf_t ovf_now, logic wrap_now, cnt_t cap_cnt);
    if (wrap_now && !cap_cnt[CNT_W-1])
      return ovf_now + ovf_t'(1);
    return ovf_now;
  endfunction

  function automatic ts_t ts_join(ovf_t hi, cnt_t lo);
    return {hi, lo};
  endfunction

  function automatic ts_t ts_span(ts_t newer, ts_t older);
    return newer - older;
  endfunction
endpackage

// File: rtl/cpm_timebase.sv
module cpm_timebase
  import cpm_pkg::*;
#(
  parameter int PRESC_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_en,
  input  logic [PRESC_W-1:0] presc_sel,
  input  logic               ovf_flag_clr,
  output logic               tick,
  output logic               wrap,
  output cnt_t               cnt_q,
  output cnt_t               cnt_nxt,
  output ovf_t               ovf_cnt_q,
  output logic               ovf_flag_q
);
  localparam int DIV_W = (1 << PRESC_W) - 1;
  localparam cnt_t CNT_TOP = '1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W:0]   div_lim;

  assign div_lim = ((DIV_W+1)'(1) << presc_sel) - (DIV_W+1)'(1);
  assign tick    = run_en && ({1'b0, div_q} >= div_lim);
  assign wrap    = tick && (cnt_q == CNT_TOP);
  assign cnt_nxt = tick ? cnt_q + cnt_t'(1) : cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else if (run_en) begin
      if (tick) div_q <= '0;
      else      div_q <= div_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_cnt_q  <= '0;
      ovf_flag_q <= 1'b0;
    end else begin
      if (wrap) ovf_cnt_q <= ovf_cnt_q + ovf_t'(1);
      if (wrap)              ovf_flag_q <= 1'b1;
      else if (ovf_flag_clr) ovf_flag_q <= 1'b0;
    end
  end
endmodule

// File: rtl/cpm_edge_detect.sv
module cpm_edge_detect
  import cpm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin,
  input  logic [1:0] edge_sel,
  output logic       sync_lvl,
  output logic       hit
);
  logic [SYNC_STAGES-1:0] chain_q;
  logic                   prev_q;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= pin;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign sync_lvl = chain_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_lvl;
  end

  assign hit = edge_hit(edge_mode_e'(edge_sel), prev_q, sync_lvl);
endmodule

// File: rtl/cpm_capture.sv
module cpm_capture
  import cpm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cap_evt,
  input  logic wrap,
  input  cnt_t cnt_nxt,
  input  ovf_t ovf_cnt_q,
  input  logic cap_flag_clr,
  output cnt_t cap_val_q,
  output ovf_t cap_ovf_q,
  output ts_t  period_q,
  output logic period_valid_q,
  output logic cap_flag_q
);
  ovf_t paired_ovf;
  ts_t  ts_now;
  ts_t  ts_prev_q;
  logic have_prev_q;

  assign paired_ovf = pair_ovf(ovf_cnt_q, wrap, cnt_nxt);
  assign ts_now     = ts_join(paired_ovf, cnt_nxt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_val_q      <= '0;
      cap_ovf_q      <= '0;
      ts_prev_q      <= '0;
      period_q       <= '0;
      have_prev_q    <= 1'b0;
      period_valid_q <= 1'b0;
    end else if (cap_evt) begin
      cap_val_q   <= cnt_nxt;
      cap_ovf_q   <= paired_ovf;
      ts_prev_q   <= ts_now;
      have_prev_q <= 1'b1;
      if (have_prev_q) begin
        period_q       <= ts_span(ts_now, ts_prev_q);
        period_valid_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cap_flag_q <= 1'b0;
    else if (cap_evt)      cap_flag_q <= 1'b1;
    else if (cap_flag_clr) cap_flag_q <= 1'b0;
  end
endmodule

// File: rtl/capture_period_meter.sv
module capture_period_meter
  import cpm_pkg::*;
#(
  parameter int PRESC_W     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_en,
  input  logic [PRESC_W-1:0] presc_sel,
  input  logic               cap_pin,
  input  logic [1:0]         edge_sel,
  input  logic               cap_flag_clr,
  input  logic               ovf_flag_clr,
  input  logic               cap_irq_en,
  input  logic               ovf_irq_en,
  output logic [CNT_W-1:0]   cnt_value,
  output logic [OVF_W-1:0]   ovf_count,
  output logic [CNT_W-1:0]   cap_value,
  output logic [OVF_W-1:0]   cap_ovf,
  output logic [TS_W-1:0]    period,
  output logic               period_valid,
  output logic               cap_flag,
  output logic               ovf_flag,
  output logic               irq
);
  // Named internal events, observed by the bound checker
  logic tick_w;
  logic wrap_w;
  logic cap_evt_w;
  logic sync_lvl_w;
  cnt_t cnt_nxt_w;

  cpm_timebase #(.PRESC_W(PRESC_W)) u_tb (
    .clk          (clk),
    .rst_n        (rst_n),
    .run_en       (run_en),
    .presc_sel    (presc_sel),
    .ovf_flag_clr (ovf_flag_clr),
    .tick         (tick_w),
    .wrap         (wrap_w),
    .cnt_q        (cnt_value),
    .cnt_nxt      (cnt_nxt_w),
    .ovf_cnt_q    (ovf_count),
    .ovf_flag_q   (ovf_flag)
  );

  cpm_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin      (cap_pin),
    .edge_sel (edge_sel),
    .sync_lvl (sync_lvl_w),
    .hit      (cap_evt_w)
  );

  cpm_capture u_cap (
    .clk            (clk),
    .rst_n          (rst_n),
    .cap_evt        (cap_evt_w),
    .wrap           (wrap_w),
    .cnt_nxt        (cnt_nxt_w),
    .ovf_cnt_q      (ovf_count),
    .cap_flag_clr   (cap_flag_clr),
    .cap_val_q      (cap_value),
    .cap_ovf_q      (cap_ovf),
    .period_q       (period),
    .period_valid_q (period_valid),
    .cap_flag_q     (cap_flag)
  );

  assign irq = (cap_flag && cap_irq_en) || (ovf_flag && ovf_irq_en);
endmodule

// File: rtl/cpm_checker.sv
module cpm_checker
  import cpm_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] edge_sel,
  input logic       cap_flag_clr,
  input logic       tick,
  input logic       wrap,
  input logic       cap_evt,
  input cnt_t       cnt_value,
  input ovf_t       ovf_count,
  input logic       ovf_flag,
  input cnt_t       cap_value,
  input ovf_t       cap_ovf,
  input logic       cap_flag,
  input logic       period_valid
);
  assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_value));

  assert_wrap_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> ovf_count == $past(ovf_count) + ovf_t'(1));

  assert_wrap_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> ovf_flag);

  assert_off_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_sel == 2'b00) |-> !cap_evt);

  assert_cap_matches_cnt_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> cap_value == cnt_value);

  assert_cap_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> cap_flag);

  assert_cap_flag_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_flag && cap_flag_clr && !cap_evt) |=> !cap_flag);

  assert_pairing_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> cap_ovf == ovf_count);

  assert_valid_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(period_valid) |-> $past(cap_evt));
endmodule

bind capture_period_meter cpm_checker chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .edge_sel     (edge_sel),
  .cap_flag_clr (cap_flag_clr),
  .tick         (tick_w),
  .wrap         (wrap_w),
  .cap_evt      (cap_evt_w),
  .cnt_value    (cnt_value),
  .ovf_count    (ovf_count),
  .ovf_flag     (ovf_flag),
  .cap_value    (cap_value),
  .cap_ovf      (cap_ovf),
  .cap_flag     (cap_flag),
  .period_valid (period_valid)
);

// File: tb/capture_period_meter_tb.sv
`timescale 1ns/1ps
module capture_period_meter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_en = 1'b0;
  logic [2:0]  presc_sel = 3'd0;
  logic        cap_pin = 1'b0;
  logic [1:0]  edge_sel = 2'b00;
  logic        cap_flag_clr = 1'b0;
  logic        ovf_flag_clr = 1'b0;
  logic        cap_irq_en = 1'b0;
  logic        ovf_irq_en = 1'b0;
  logic [15:0] cnt_value, ovf_count, cap_value, cap_ovf;
  logic [31:0] period;
  logic        period_valid, cap_flag, ovf_flag, irq;

  int n_checks = 0;
  int n_fail = 0;
  int unsigned edges = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) edges <= edges + 1;

  capture_period_meter dut_i (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .presc_sel(presc_sel),
    .cap_pin(cap_pin), .edge_sel(edge_sel), .cap_flag_clr(cap_flag_clr),
    .ovf_flag_clr(ovf_flag_clr), .cap_irq_en(cap_irq_en), .ovf_irq_en(ovf_irq_en),
    .cnt_value(cnt_value), .ovf_count(ovf_count), .cap_value(cap_value),
    .cap_ovf(cap_ovf), .period(period), .period_valid(period_valid),
    .cap_flag(cap_flag), .ovf_flag(ovf_flag), .irq(irq)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_cap_flag();
    cap_flag_clr = 1'b1; cyc(1); cap_flag_clr = 1'b0;
  endtask

  // One pin change under one mode; checks capture or its absence (R4, R5, R6)
  task automatic edge_case(bit lvl, logic [1:0] mode, bit want);
    logic [15:0] old_cap;
    edge_sel = mode;
    clear_cap_flag();
    old_cap = cap_value;
    cap_pin = lvl;
    cyc(3);
    check("R6", "cap_flag after pin change", {31'd0, cap_flag}, {31'd0, want});
    if (want) check("R5", "cap_value equals counter", {16'd0, cap_value}, {16'd0, cnt_value});
    else      check("R4", "cap_value unchanged", {16'd0, cap_value}, {16'd0, old_cap});
  endtask

  task automatic t_reset();
    check("R1", "cnt_value", {16'd0, cnt_value}, 32'd0);
    check("R1", "ovf_count", {16'd0, ovf_count}, 32'd0);
    check("R1", "cap_value/cap_ovf", {cap_ovf, cap_value}, 32'd0);
    check("R1", "period", period, 32'd0);
    check("R1", "flags/valid/irq", {28'd0, cap_flag, ovf_flag, period_valid, irq}, 32'd0);
  endtask

  task automatic t_prescale();
    logic [15:0] a;
    run_en = 1'b1; presc_sel = 3'd0;
    cyc(1); a = cnt_value; cyc(10);
    check("R2", "divide by 1 over 10 cycles", {16'd0, cnt_value}, {16'd0, a + 16'd10});
    presc_sel = 3'd2;
    a = cnt_value; cyc(16);
    check("R2", "divide by 4 over 16 cycles", {16'd0, cnt_value}, {16'd0, a + 16'd4});
    run_en = 1'b0;
    cyc(1); a = cnt_value; cyc(10);
    check("R2", "held while stopped", {16'd0, cnt_value}, {16'd0, a});
    presc_sel = 3'd0; run_en = 1'b1;
    cyc(2);
  endtask

  task automatic t_edges();
    edge_case(1'b1, 2'b01, 1'b1);
    check("R9", "no period after first capture", {31'd0, period_valid}, 32'd0);
    edge_case(1'b0, 2'b01, 1'b0);
    edge_case(1'b1, 2'b10, 1'b0);
    edge_case(1'b0, 2'b10, 1'b1);
    check("R9", "period valid after second capture", {31'd0, period_valid}, 32'd1);
    edge_case(1'b1, 2'b11, 1'b1);
    edge_case(1'b0, 2'b11, 1'b1);
    edge_case(1'b1, 2'b00, 1'b0);
    edge_case(1'b0, 2'b00, 1'b0);
    // R6: capture and clear on the same edge, set wins
    edge_sel = 2'b11;
    clear_cap_flag();
    cap_pin = 1'b1;
    cyc(2); cap_flag_clr = 1'b1; cyc(1); cap_flag_clr = 1'b0;
    check("R6", "set wins over clear", {31'd0, cap_flag}, 32'd1);
    cap_irq_en = 1'b1; #1;
    check("R11", "irq from capture flag", {31'd0, irq}, 32'd1);
    cyc(1); clear_cap_flag(); #1;
    check("R11", "irq drops with flag", {31'd0, irq}, 32'd0);
    cap_irq_en = 1'b0;
    edge_sel = 2'b00; cap_pin = 1'b0; cyc(4);
  endtask

  task automatic t_width();
    int unsigned e_rise;
    logic [15:0] v1;
    edge_sel = 2'b01; cyc(1);
    e_rise = edges;
    cap_pin = 1'b1;
    cyc(3);
    v1 = cap_value;
    edge_sel = 2'b10;
    while (edges - e_rise < 37) cyc(1);
    cap_pin = 1'b0;
    cyc(3);
    check("R10", "width from capture difference", {16'd0, cap_value - v1}, 32'd37);
    check("R9", "period equals width", period, 32'd37);
  endtask

  task automatic t_wrap_and_period();
    int unsigned e_a, e_b;
    logic [15:0] o;
    clear_cap_flag();
    while (cnt_value != 16'hFF00) cyc(1);
    edge_sel = 2'b11;
    e_a = edges;
    cap_pin = 1'b1;
    cyc(3);
    while (cnt_value != 16'hFFF0) cyc(1);
    o = ovf_count;
    check("R3", "no wrap flag before wrap", {31'd0, ovf_flag}, 32'd0);
    cyc(16);
    check("R3", "counter wrapped to zero", {16'd0, cnt_value}, 32'd0);
    check("R3", "wrap count incremented", {16'd0, ovf_count}, {16'd0, o + 16'd1});
    check("R3", "wrap flag set", {31'd0, ovf_flag}, 32'd1);
    clear_cap_flag(); #1;
    check("R11", "irq low with enables off", {31'd0, irq}, 32'd0);
    ovf_irq_en = 1'b1; #1;
    check("R11", "irq from wrap flag", {31'd0, irq}, 32'd1);
    cyc(1);
    ovf_flag_clr = 1'b1; cyc(1); ovf_flag_clr = 1'b0;
    check("R7", "wrap flag cleared", {31'd0, ovf_flag}, 32'd0);
    check("R11", "irq dropped", {31'd0, irq}, 32'd0);
    ovf_irq_en = 1'b0;
    // Capture landing exactly on the wrap edge, with a wrap-flag clear there too
    while (cnt_value != 16'hFFFD) cyc(1);
    e_b = edges;
    cap_pin = 1'b0;
    cyc(2); ovf_flag_clr = 1'b1; cyc(1); ovf_flag_clr = 1'b0;
    check("R8", "captured count on wrap edge", {16'd0, cap_value}, 32'd0);
    check("R8", "paired wrap count", {16'd0, cap_ovf}, {16'd0, ovf_count});
    check("R3", "second wrap counted", {16'd0, ovf_count}, {16'd0, o + 16'd2});
    check("R7", "wrap set wins over clear", {31'd0, ovf_flag}, 32'd1);
    check("R9", "period across wraps", period, e_b - e_a);
  endtask

  initial begin
    cyc(4);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_prescale();
    t_edges();
    t_width();
    t_wrap_and_period();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule